// File: doc/BRIEF.md
# Programmable Clock Divider Bank with Aligned Fixed Taps

This block divides one input clock by a programmable ratio N and, beside that output, drives two fixed-ratio taps. The first tap always divides by 2. The second tap divides by 3 or by 4, and a build parameter picks which. Both tap counters return to their phase-zero state at each rising edge of the divide-by-N output. As a result, every tap's rising edge coincides with a divide-by-N rising edge. When N meets the tap's divisibility rule, the tap runs as a clean periodic clock.

A new N is presented on `n_i` together with the one-cycle `load_i` strobe. A legal value is held as pending and takes effect at the next divide-by-N period boundary, so no period is ever cut short. An illegal value is dropped and reported. A sticky flag reports that an enabled tap is running with an N that breaks its alignment rule. The block has two resets. The asynchronous reset `rst_ni` and the synchronous reset `sync_rst_i` both return the bank to N = 8 with all outputs low.

Top module: `div_bank`

## Requirements
- R1: A load with N from 4 to 127 inclusive is accepted. The divide-by-N output then runs with a period of exactly N input cycles.
- R2: A load with N of 0 to 3 is rejected, and the active N stays unchanged. `bad_n_o` is 1 in the cycle after an illegal load and 0 in the cycle after a legal load. It holds its value when there is no load.
- R3: Each divide-by-N period starts with floor(N/2) high cycles, followed by the remaining cycles low.
- R4: A newly loaded N first applies to the period that begins at the next period boundary. The period that is running completes with the old N.
- R5: `tap_a_o` divides by 2 and is high for 1 of every 2 cycles. It is high in the first cycle of every divide-by-N period.
- R6: With `TAP_MODE` = 0, `tap_b_o` divides by 3 and is high for 1 of every 3 cycles. With `TAP_MODE` = 1, it divides by 4 and is high for 2 of every 4 cycles. In both modes it is high in the first cycle of every divide-by-N period.
- R7: Both tap counters restart at every divide-by-N rising edge. When N is not a multiple of a tap's ratio, the tap's last pulse in the period is shortened.
- R8: `tap_en_i[0]` gates `tap_a_o` and `tap_en_i[1]` gates `tap_b_o`. A tap whose enable bit is 0 stays low.
- R9: `ratio_err_o` is set when an enabled tap runs with an N that breaks its rule. The rule for the divide-by-2 tap is N mod 4 = 0. The rule for the divide-by-3 tap is N = 6. The rule for the divide-by-4 tap is N mod 8 = 0. Once set, `ratio_err_o` stays set until a reset.
- R10: Either reset sets N to 8, clears both flags and drives all outputs low. The first divide-by-N rising edge, with the enabled taps rising together, comes at the first clock edge after reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_rst_i | input | 1 | Synchronous reset, active high |
| n_i | input | 7 | Requested divide ratio N |
| load_i | input | 1 | One-cycle strobe that loads `n_i` |
| tap_en_i | input | 2 | Tap enables: bit 0 for the divide-by-2 tap, bit 1 for the second tap |
| divn_o | output | 1 | Divide-by-N output |
| tap_a_o | output | 1 | Fixed divide-by-2 tap |
| tap_b_o | output | 1 | Fixed divide-by-3 or divide-by-4 tap |
| bad_n_o | output | 1 | The last load was out of range |
| ratio_err_o | output | 1 | Sticky flag: an enabled tap broke its divisibility rule |

## Verification
The assertions assume that `load_i`, `n_i`, `tap_en_i` and `sync_rst_i` change only between rising clock edges. They also assume that `tap_en_i` is steady around each divide-by-N rising edge, since the tap alignment checks sample it there. The stimulus drives every input on the falling edge, changes enables only between measured periods, and keeps `load_i` to single-cycle pulses.

// File: rtl/div_bank_pkg.sv
package div_bank_pkg;

  typedef enum logic {
    TAPS_2_3 = 1'b0,
    TAPS_2_4 = 1'b1
  } tap_mode_e;

  function automatic int unsigned tap_b_ratio(tap_mode_e mode);
    return (mode == TAPS_2_4) ? 4 : 3;
  endfunction

  function automatic logic n_in_range(int unsigned n, int unsigned lo, int unsigned hi);
    return (n >= lo) && (n <= hi);
  endfunction

  // power-of-two ratio R needs N % 2R == 0, any other ratio needs N == 2R
  function automatic logic tap_rule_ok(int unsigned ratio, int unsigned n);
    if ((ratio & (ratio - 1)) == 0) return (n % (2 * ratio)) == 0;
    return n == 2 * ratio;
  endfunction

endpackage

// File: rtl/div_bank_ctrl.sv
module div_bank_ctrl
  import div_bank_pkg::*;
#(
  parameter int unsigned N_W     = 7,
  parameter int unsigned N_MIN   = 4,
  parameter int unsigned N_MAX   = 127,
  parameter int unsigned N_RST   = 8,
  parameter int unsigned RATIO_A = 2,
  parameter int unsigned RATIO_B = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sync_rst_i,
  input  logic [N_W-1:0] n_i,
  input  logic           load_i,
  input  logic           wrap_i,
  input  logic [1:0]     tap_en_i,
  output logic [N_W-1:0] n_act_o,
  output logic [N_W-1:0] n_next_o,
  output logic           bad_n_o,
  output logic           ratio_err_o
);

  localparam logic [N_W-1:0] RST_V = N_W'(N_RST);

  logic [N_W-1:0] n_q, pend_q, cand;
  logic           pend_vld_q, bad_q, err_q;
  logic           load_ok, cand_vld, viol;

  assign load_ok  = load_i && n_in_range(32'(n_i), N_MIN, N_MAX);
  assign cand     = load_ok ? n_i : pend_q;
  assign cand_vld = load_ok || pend_vld_q;
  assign n_next_o = (wrap_i && cand_vld) ? cand : n_q;

  assign viol = (tap_en_i[0] && !tap_rule_ok(RATIO_A, 32'(n_q))) ||
                (tap_en_i[1] && !tap_rule_ok(RATIO_B, 32'(n_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q        <= RST_V;
      pend_q     <= RST_V;
      pend_vld_q <= 1'b0;
      bad_q      <= 1'b0;
      err_q      <= 1'b0;
    end else if (sync_rst_i) begin
      n_q        <= RST_V;
      pend_q     <= RST_V;
      pend_vld_q <= 1'b0;
      bad_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      n_q <= n_next_o;
      if (wrap_i) begin
        pend_vld_q <= 1'b0;
      end else if (load_ok) begin
        pend_q     <= n_i;
        pend_vld_q <= 1'b1;
      end
      if (load_i) bad_q <= !load_ok;
      err_q <= err_q || viol;
    end
  end

  assign n_act_o     = n_q;
  assign bad_n_o     = bad_q;
  assign ratio_err_o = err_q;

endmodule

// File: rtl/div_bank_core.sv
module div_bank_core #(
  parameter int unsigned N_W   = 7,
  parameter int unsigned N_RST = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sync_rst_i,
  input  logic [N_W-1:0] n_act_i,
  input  logic [N_W-1:0] n_next_i,
  output logic           wrap_o,
  output logic           divn_o
);

  localparam logic [N_W-1:0] ONE    = N_W'(1);
  localparam logic [N_W-1:0] CNT_RST = N_W'(N_RST - 1);

  logic [N_W-1:0] cnt_q, cnt_d;
  logic           divn_q;

  assign wrap_o = (cnt_q == n_act_i - ONE);
  assign cnt_d  = wrap_o ? '0 : cnt_q + ONE;

  // reset parks the count on the last (low) phase of an N_RST period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_RST;
      divn_q <= 1'b0;
    end else if (sync_rst_i) begin
      cnt_q  <= CNT_RST;
      divn_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      divn_q <= cnt_d < (n_next_i >> 1);
    end
  end

  assign divn_o = divn_q;

endmodule

// File: rtl/div_bank_tap.sv
module div_bank_tap #(
  parameter int unsigned RATIO = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_rst_i,
  input  logic restart_i,
  input  logic en_i,
  output logic tap_o
);

  localparam int unsigned   K_W    = $clog2(RATIO);
  localparam logic [K_W-1:0] LAST  = K_W'(RATIO - 1);
  localparam logic [K_W-1:0] HALF  = K_W'(RATIO / 2);
  localparam logic [K_W-1:0] K_ONE = K_W'(1);

  logic [K_W-1:0] k_q, k_d;
  logic           tap_q;

  assign k_d = (restart_i || k_q == LAST) ? '0 : k_q + K_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q   <= LAST;
      tap_q <= 1'b0;
    end else if (sync_rst_i) begin
      k_q   <= LAST;
      tap_q <= 1'b0;
    end else begin
      k_q   <= k_d;
      tap_q <= k_d < HALF;
    end
  end

  assign tap_o = tap_q && en_i;

endmodule

// File: rtl/div_bank.sv
module div_bank
  import div_bank_pkg::*;
#(
  parameter int unsigned N_W      = 7,
  parameter int unsigned N_MIN    = 4,
  parameter int unsigned N_MAX    = 127,
  parameter int unsigned N_RST    = 8,
  parameter tap_mode_e   TAP_MODE = TAPS_2_3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sync_rst_i,
  input  logic [N_W-1:0] n_i,
  input  logic           load_i,
  input  logic [1:0]     tap_en_i,
  output logic           divn_o,
  output logic           tap_a_o,
  output logic           tap_b_o,
  output logic           bad_n_o,
  output logic           ratio_err_o
);

  localparam int unsigned RATIO_A = 2;
  localparam int unsigned RATIO_B = tap_b_ratio(TAP_MODE);

  logic [N_W-1:0] n_act, n_next;
  logic           wrap;
  logic [1:0]     tap_w;

  div_bank_ctrl #(
    .N_W(N_W), .N_MIN(N_MIN), .N_MAX(N_MAX), .N_RST(N_RST),
    .RATIO_A(RATIO_A), .RATIO_B(RATIO_B)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_rst_i  (sync_rst_i),
    .n_i         (n_i),
    .load_i      (load_i),
    .wrap_i      (wrap),
    .tap_en_i    (tap_en_i),
    .n_act_o     (n_act),
    .n_next_o    (n_next),
    .bad_n_o     (bad_n_o),
    .ratio_err_o (ratio_err_o)
  );

  div_bank_core #(.N_W(N_W), .N_RST(N_RST)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_rst_i (sync_rst_i),
    .n_act_i    (n_act),
    .n_next_i   (n_next),
    .wrap_o     (wrap),
    .divn_o     (divn_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_tap
    div_bank_tap #(.RATIO(g == 0 ? RATIO_A : RATIO_B)) u_tap (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sync_rst_i (sync_rst_i),
      .restart_i  (wrap),
      .en_i       (tap_en_i[g]),
      .tap_o      (tap_w[g])
    );
  end

  assign tap_a_o = tap_w[0];
  assign tap_b_o = tap_w[1];

endmodule

// File: rtl/div_bank_chk.sv
module div_bank_chk
  import div_bank_pkg::*;
#(
  parameter int unsigned N_W   = 7,
  parameter int unsigned N_MIN = 4,
  parameter int unsigned N_MAX = 127,
  parameter int unsigned N_RST = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sync_rst_i,
  input logic [N_W-1:0] n_i,
  input logic           load_i,
  input logic [1:0]     tap_en_i,
  input logic           divn_o,
  input logic           tap_a_o,
  input logic           tap_b_o,
  input logic           bad_n_o,
  input logic           ratio_err_o,
  input logic [N_W-1:0] n_act,
  input logic           wrap
);

  localparam logic [N_W-1:0] RST_V = N_W'(N_RST);

  logic n_i_ok;
  assign n_i_ok = n_in_range(32'(n_i), N_MIN, N_MAX);

  assert_active_n_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_in_range(32'(n_act), N_MIN, N_MAX));

  assert_bad_load_flagged_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !n_i_ok && !sync_rst_i |=> bad_n_o);

  assert_good_load_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && n_i_ok && !sync_rst_i |=> !bad_n_o);

  assert_n_changes_at_boundary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(n_act) && !$past(sync_rst_i) |-> $past(wrap));

  assert_tap_a_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(divn_o) && tap_en_i[0] |-> tap_a_o);

  assert_tap_b_aligned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(divn_o) && tap_en_i[1] |-> tap_b_o);

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_err_o && !sync_rst_i |=> ratio_err_o);

  assert_sync_reset_state_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rst_i |=> !divn_o && !tap_a_o && !tap_b_o && !bad_n_o && !ratio_err_o &&
                   n_act == RST_V);

endmodule

bind div_bank div_bank_chk #(
  .N_W(N_W), .N_MIN(N_MIN), .N_MAX(N_MAX), .N_RST(N_RST)
) u_chk (.*);

// File: tb/div_bank_test.sv
module div_bank_test;
  import div_bank_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_rst_i = 1'b0;
  logic [6:0] n_i = 7'd8;
  logic       load_i = 1'b0;
  logic [1:0] tap_en_i = 2'b01;
  logic       divn_o, tap_a_o, tap_b_o, bad_n_o, ratio_err_o;
  logic       divn_b, tap_a_b, tap_b4, bad_b, err_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  div_bank #(.TAP_MODE(TAPS_2_3)) uut (
    .clk_i, .rst_ni, .sync_rst_i, .n_i, .load_i, .tap_en_i,
    .divn_o, .tap_a_o, .tap_b_o, .bad_n_o, .ratio_err_o
  );

  div_bank #(.TAP_MODE(TAPS_2_4)) uut_b (
    .clk_i, .rst_ni, .sync_rst_i, .n_i, .load_i, .tap_en_i,
    .divn_o(divn_b), .tap_a_o(tap_a_b), .tap_b_o(tap_b4),
    .bad_n_o(bad_b), .ratio_err_o(err_b)
  );

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = divn_o;
    @(negedge clk_i);
    while (!(!prev && divn_o)) begin
      prev = divn_o;
      @(negedge clk_i);
    end
  endtask

  // measures one full divide-by-N period starting at the next rising edge
  task automatic meas(output int tot, output int hi, output int ta, output int tb,
                      output int tb4, output int ra, output int rb, output int rb4);
    logic prev;
    wait_rise();
    tot = 1; hi = 1;
    ta = int'(tap_a_o); tb = int'(tap_b_o); tb4 = int'(tap_b4);
    ra = int'(tap_a_o); rb = int'(tap_b_o); rb4 = int'(tap_b4);
    prev = divn_o;
    @(negedge clk_i);
    while (!(!prev && divn_o)) begin
      tot++;
      hi  += int'(divn_o);
      ta  += int'(tap_a_o);
      tb  += int'(tap_b_o);
      tb4 += int'(tap_b4);
      prev = divn_o;
      @(negedge clk_i);
    end
  endtask

  task automatic do_load(int n);
    n_i    = 7'(n);
    load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic t_reset();
    int tot, hi, ta, tb, tb4, ra, rb, rb4;
    repeat (3) @(negedge clk_i);
    chk("R10 divn in reset", int'(divn_o), 0);
    rst_ni = 1'b1;
    chk("R10 divn before first edge", int'(divn_o), 0);
    chk("R10 tap_a before first edge", int'(tap_a_o), 0);
    @(negedge clk_i);
    chk("R10 divn rises at first edge", int'(divn_o), 1);
    chk("R10 tap_a rises with divn", int'(tap_a_o), 1);
    chk("R10 bad flag clear", int'(bad_n_o), 0);
    chk("R10 ratio flag clear", int'(ratio_err_o), 0);
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R10 reset period is 8", tot, 8);
    chk("R3 reset high time", hi, 4);
  endtask

  task automatic t_range();
    int tot, hi, ta, tb, tb4, ra, rb, rb4;
    do_load(4);
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R1 period N=4", tot, 4);
    chk("R3 high N=4", hi, 2);
    do_load(127);
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R1 period N=127", tot, 127);
    chk("R3 high N=127", hi, 63);
    do_load(5);
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R1 period N=5", tot, 5);
    chk("R3 high N=5", hi, 2);
  endtask

  task automatic t_invalid();
    int tot, hi, ta, tb, tb4, ra, rb, rb4;
    do_load(3);
    chk("R2 bad flag after N=3", int'(bad_n_o), 1);
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R2 N kept after N=3", tot, 5);
    do_load(0);
    chk("R2 bad flag after N=0", int'(bad_n_o), 1);
    @(negedge clk_i);
    chk("R2 bad flag holds", int'(bad_n_o), 1);
    do_load(8);
    chk("R2 bad flag cleared by legal load", int'(bad_n_o), 0);
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R2 legal load applied", tot, 8);
  endtask

  task automatic t_switch();
    int tot, hi, ta, tb, tb4, ra, rb, rb4, steps;
    logic prev;
    wait_rise();
    n_i = 7'd12;
    load_i = 1'b1;
    steps = 0;
    prev = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
    steps++;
    while (!(!prev && divn_o)) begin
      prev = divn_o;
      @(negedge clk_i);
      steps++;
    end
    chk("R4 running period keeps old N", steps, 8);
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R4 next period uses new N", tot, 12);
    chk("R3 high N=12", hi, 6);
  endtask

  task automatic t_taps();
    int tot, hi, ta, tb, tb4, ra, rb, rb4;
    tap_en_i = 2'b11;
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R5 div2 high count N=12", ta, 6);
    chk("R5 div2 aligned N=12", ra, 1);
    chk("R6 div3 high count N=12", tb, 4);
    chk("R6 div3 aligned N=12", rb, 1);
    chk("R6 div4 high count N=12", tb4, 6);
    chk("R6 div4 aligned N=12", rb4, 1);
    do_load(6);
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R5 div2 high count N=6", ta, 3);
    chk("R6 div3 high count N=6", tb, 2);
    chk("R6 div3 aligned N=6", rb, 1);
    chk("R6 div4 high count N=6", tb4, 4);
    do_load(5);
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R7 div2 restart N=5 count", ta, 3);
    chk("R7 div3 restart N=5 count", tb, 2);
    chk("R7 div4 restart N=5 count", tb4, 3);
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R7 div3 restarted at rise", rb, 1);
    chk("R7 div4 restarted at rise", rb4, 1);
    chk("R7 div2 restarted at rise", ra, 1);
  endtask

  task automatic t_enable();
    int tot, hi, ta, tb, tb4, ra, rb, rb4;
    tap_en_i = 2'b00;
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R8 tap_a held low", ta, 0);
    chk("R8 tap_b held low", tb, 0);
    chk("R8 divn still runs", tot, 5);
    tap_en_i = 2'b10;
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R8 tap_a off while tap_b on", ta, 0);
    chk("R8 tap_b on", rb, 1);
  endtask

  task automatic t_sticky();
    int tot, hi, ta, tb, tb4, ra, rb, rb4;
    tap_en_i   = 2'b01;
    sync_rst_i = 1'b1;
    @(negedge clk_i);
    sync_rst_i = 1'b0;
    chk("R10 sync reset divn low", int'(divn_o), 0);
    chk("R10 sync reset tap_a low", int'(tap_a_o), 0);
    chk("R10 sync reset ratio flag", int'(ratio_err_o), 0);
    chk("R10 sync reset bad flag", int'(bad_n_o), 0);
    @(negedge clk_i);
    chk("R10 divn rises after sync reset", int'(divn_o), 1);
    chk("R10 tap_a rises after sync reset", int'(tap_a_o), 1);
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R10 sync reset period is 8", tot, 8);
    chk("R9 div2 with N=8 no flag", int'(ratio_err_o), 0);
    tap_en_i = 2'b11;
    repeat (2) @(negedge clk_i);
    chk("R9 div3 with N=8 sets flag", int'(ratio_err_o), 1);
    tap_en_i = 2'b00;
    repeat (3) @(negedge clk_i);
    chk("R9 flag sticky after disable", int'(ratio_err_o), 1);
    do_load(6);
    tap_en_i = 2'b10;
    meas(tot, hi, ta, tb, tb4, ra, rb, rb4);
    chk("R9 flag sticky with legal N", int'(ratio_err_o), 1);
  endtask

  initial begin
    t_reset();
    t_range();
    t_invalid();
    t_switch();
    t_taps();
    t_enable();
    t_sticky();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule